// File: doc/BRIEF.md
# Bitmap Transport Packet Identifier Filter

This block sits on a byte-wide transport stream and decides, packet by packet, whether each packet travels on or is discarded. Each packet is 188 bytes long and is marked by a start flag on its first byte. The block gathers the first eight bytes into a 64-bit big-endian word and cuts a programmable bit slice out of that word as the packet's identifier. The identifier then indexes a table that holds one bit per possible identifier, 8192 bits in total.

A packet whose table bit is 1 is copied unchanged to the output. A packet whose bit is 0 produces no output at all. Clearing the enable lets every packet through whatever the table holds. Software can set or clear single table bits, wipe the whole table in one cycle, and load the slice offset, the slice width and the enable.

Every packet is held in full before it leaves. Two packet banks let the next packet arrive while the previous one drains, so packets can arrive back to back with no gap.

Top module: `ts_pid_filter`

## Requirements
- R1: After reset nothing is output, every table bit is 0, the enable is 1, the slice offset is 40 and the slice width is 13.
- R2: A packet begins with a byte that has in_valid and in_sop both high and is exactly 188 accepted bytes long. A valid byte without in_sop while no packet is open is ignored. A byte with in_sop inside an open packet abandons that packet and starts a new one.
- R3: Header bytes 0..7 form a word with byte 0 in bits 63:56 and byte 7 in bits 7:0. The identifier is (word >> offset) & ((1 << width) - 1), and only its low 13 bits are kept. Word bits above 63 count as 0.
- R4: With the enable at 1, a packet is forwarded when its identifier's table bit is 1. When the bit is 0, the packet is dropped and produces no output byte.
- R5: With the enable at 0, every complete packet is forwarded whatever the table holds.
- R6: A forwarded packet leaves as 188 bytes on consecutive cycles with out_valid high and out_sop high on the first byte only. The bytes are unchanged and packets keep their arrival order. The first byte appears two clock edges after the edge that accepted the packet's last byte, or on the edge after the previous output packet's last byte if that is later.
- R7: tbl_we writes tbl_val into the bit at tbl_addr. The decision uses the table and the enable as they stand when byte 7 of the packet is accepted, so a write made before the packet's start byte always applies to it.
- R8: tbl_clr sets every table bit to 0 and wins over tbl_we in the same cycle.
- R9: cfg_we loads the slice offset, the slice width and the enable. The new values apply to packets whose byte 7 arrives later.
- R10: Packets arriving with no idle cycle between them are all handled with none lost or corrupted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is first of a packet |
| in_data | input | 8 | Input byte |
| tbl_we | input | 1 | Write one table bit |
| tbl_addr | input | 13 | Identifier whose bit is written |
| tbl_val | input | 1 | Value written to the table bit |
| tbl_clr | input | 1 | Set the whole table to 0 |
| cfg_we | input | 1 | Load offset, width and enable |
| cfg_off_in | input | 6 | Slice offset (lowest bit position) |
| cfg_wid_in | input | 4 | Slice width in bits |
| cfg_en_in | input | 1 | Filtering enable; 0 passes everything |
| out_valid | output | 1 | Output byte valid |
| out_sop | output | 1 | Output byte is first of a packet |
| out_data | output | 8 | Output byte |

## Verification
The assertions take for granted that the input carries at most one byte per cycle, which is the fact that keeps the two-bank store from being overwritten while it drains. They also assume the table is written only between packets when a test depends on the result of that write. The stimulus drives at most one byte per clock, with packets either back to back or separated by idle cycles. It issues table and configuration writes only while the input is idle. A behavioural model in the bench predicts the output on every cycle. Dedicated scenarios cover stray bytes, restarted packets, out-of-range slices and a clear arriving together with a write.

// File: rtl/ts_pid_filter.sv
module ts_pid_filter #(
  parameter int PKT_LEN = 188,
  parameter int ID_W    = 13,
  parameter int OFF_DEF = 40,
  parameter int WID_DEF = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_sop,
  input  logic [7:0]      in_data,
  input  logic            tbl_we,
  input  logic [ID_W-1:0] tbl_addr,
  input  logic            tbl_val,
  input  logic            tbl_clr,
  input  logic            cfg_we,
  input  logic [5:0]      cfg_off_in,
  input  logic [3:0]      cfg_wid_in,
  input  logic            cfg_en_in,
  output logic            out_valid,
  output logic            out_sop,
  output logic [7:0]      out_data
);
  localparam int NW    = (2 ** ID_W) / 32;
  localparam int IDX_W = $clog2(PKT_LEN);
  localparam int MA_W  = $clog2(2 * PKT_LEN);
  localparam int LAST  = PKT_LEN - 1;

  logic [5:0]  cfg_off;
  logic [3:0]  cfg_wid;
  logic        cfg_en;
  logic [31:0] tbl [NW];
  logic [7:0]  mem [2*PKT_LEN];

  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic             rx_act, wr_bank, rd_bank, keep_r, drain;
  logic [55:0]      hdr;
  logic [1:0]       full, full_nx;
  logic [ID_W-1:0]  id;
  logic [63:0]      word;

  wire              take     = in_valid && (in_sop || rx_act);
  wire [IDX_W-1:0]  cur_idx  = in_sop ? '0 : wr_idx;
  wire              hdr_last = take && (cur_idx == IDX_W'(7));
  wire              pkt_done = take && (cur_idx == IDX_W'(LAST));
  wire              pass_now = !cfg_en || tbl[id[ID_W-1:5]][id[4:0]];
  wire              drain_end = drain && (rd_idx == IDX_W'(LAST));
  wire [MA_W-1:0]   waddr = MA_W'(cur_idx) + (wr_bank ? MA_W'(PKT_LEN) : '0);
  wire [MA_W-1:0]   raddr = MA_W'(rd_idx) + (rd_bank ? MA_W'(PKT_LEN) : '0);

  assign word = {hdr, in_data};

  always_comb begin
    for (int k = 0; k < ID_W; k++) begin
      int pos;
      pos = int'(cfg_off) + k;
      id[k] = (k < int'(cfg_wid)) && (pos < 64) && word[pos[5:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_off <= 6'(OFF_DEF);
      cfg_wid <= 4'(WID_DEF);
      cfg_en  <= 1'b1;
      for (int w = 0; w < NW; w++) tbl[w] <= '0;
    end else begin
      if (cfg_we) begin
        cfg_off <= cfg_off_in;
        cfg_wid <= cfg_wid_in;
        cfg_en  <= cfg_en_in;
      end
      if (tbl_clr) begin
        for (int w = 0; w < NW; w++) tbl[w] <= '0;
      end else if (tbl_we) begin
        tbl[tbl_addr[ID_W-1:5]][tbl_addr[4:0]] <= tbl_val;
      end
    end
  end

  always_comb begin
    full_nx = full;
    if (drain_end) full_nx[rd_bank] = 1'b0;
    if (pkt_done && keep_r) full_nx[wr_bank] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_act  <= 1'b0;
      wr_idx  <= '0;
      wr_bank <= 1'b0;
      hdr     <= '0;
      keep_r  <= 1'b0;
      full    <= '0;
    end else begin
      full <= full_nx;
      if (take) begin
        rx_act <= !pkt_done;
        wr_idx <= pkt_done ? '0 : cur_idx + 1'b1;
        if (cur_idx < IDX_W'(7)) hdr <= {hdr[47:0], in_data};
        if (hdr_last) keep_r <= pass_now;
        if (pkt_done && keep_r) wr_bank <= ~wr_bank;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) mem[waddr] <= in_data;
    if (drain) out_data <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drain     <= 1'b0;
      rd_bank   <= 1'b0;
      rd_idx    <= '0;
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
    end else if (drain) begin
      out_valid <= 1'b1;
      out_sop   <= (rd_idx == '0);
      if (drain_end) begin
        rd_bank <= ~rd_bank;
        rd_idx  <= '0;
        drain   <= full[~rd_bank];
      end else begin
        rd_idx <= rd_idx + 1'b1;
      end
    end else begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      rd_idx    <= '0;
      if (full[rd_bank]) drain <= 1'b1;
    end
  end

  p_sop_has_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> out_valid);

  p_first_is_sop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_sop);

  p_contiguous_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sop) |-> $past(out_valid));

  p_no_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && keep_r) |-> !full[wr_bank]);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_clr |=> (tbl[0] == '0 && tbl[NW-1] == '0));

  p_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_we && !tbl_clr) |=>
      (tbl[$past(tbl_addr[ID_W-1:5])][$past(tbl_addr[4:0])] == $past(tbl_val)));
endmodule

// File: tb/sim_ts_pid_filter.sv
module sim_ts_pid_filter;
  localparam int CLK_PERIOD = 10;
  localparam int PLEN = 188;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sop = 0;
  logic [7:0] in_data = 0;
  logic tbl_we = 0, tbl_val = 0, tbl_clr = 0, cfg_we = 0, cfg_en_in = 1;
  logic [12:0] tbl_addr = 0;
  logic [5:0] cfg_off_in = 40;
  logic [3:0] cfg_wid_in = 13;
  logic out_valid, out_sop;
  logic [7:0] out_data;

  ts_pid_filter u0 (.clk, .rst_n, .in_valid, .in_sop, .in_data, .tbl_we, .tbl_addr,
    .tbl_val, .tbl_clr, .cfg_we, .cfg_off_in, .cfg_wid_in, .cfg_en_in,
    .out_valid, .out_sop, .out_data);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, fails = 0, pkt_cnt = 0;
  longint cyc = 0;
  bit done = 0;

  bit mtbl [8192];
  int moff = 40, mwid = 13;
  bit men = 1;
  int mbuf [PLEN];
  int mcnt = 0;
  bit mact = 0, mdec = 0;
  longint next_free = 0;
  longint exp_t [$];
  int exp_d [$];
  bit exp_s [$];

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  function automatic bit model_pass();
    longint unsigned w, idv;
    w = 0;
    for (int i = 0; i < 8; i++) w = (w << 8) | longint'(mbuf[i]);
    idv = (moff >= 64) ? 0 : (w >> moff);
    idv = idv & ((64'd1 << mwid) - 1);
    idv = idv & 64'h1fff;
    return !men || mtbl[int'(idv)];
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (in_valid && (in_sop || mact)) begin
        if (in_sop) mcnt = 0;
        mbuf[mcnt] = int'(in_data);
        if (mcnt == 7) mdec = model_pass();
        if (mcnt == PLEN - 1) begin
          mact = 0;
          if (mdec) begin
            longint st;
            st = (cyc + 2 > next_free) ? cyc + 2 : next_free;
            for (int i = 0; i < PLEN; i++) begin
              exp_t.push_back(st + i);
              exp_d.push_back(mbuf[i]);
              exp_s.push_back(i == 0);
            end
            next_free = st + PLEN;
          end
        end else begin
          mact = 1;
          mcnt++;
        end
      end
      if (tbl_clr) begin
        for (int i = 0; i < 8192; i++) mtbl[i] = 0;
      end else if (tbl_we) mtbl[tbl_addr] = tbl_val;
      if (cfg_we) begin
        moff = int'(cfg_off_in);
        mwid = int'(cfg_wid_in);
        men = cfg_en_in;
      end
    end
    if (cyc > 150000) begin
      chk(0, "R6", "watchdog expired", cyc, 150000);
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (out_valid && out_sop) pkt_cnt++;
    if (exp_t.size() > 0 && exp_t[0] == cyc) begin
      chk(out_valid == 1'b1, "R6", "out_valid", longint'(out_valid), 1);
      chk(out_sop == exp_s[0], "R6", "out_sop", longint'(out_sop), longint'(exp_s[0]));
      chk(int'(out_data) == exp_d[0], "R6", "out_data", longint'(out_data), longint'(exp_d[0]));
      void'(exp_t.pop_front());
      void'(exp_d.pop_front());
      void'(exp_s.pop_front());
    end else begin
      chk(out_valid == 1'b0, "R4", "unexpected out_valid", longint'(out_valid), 0);
    end
  end

  task automatic send(logic [63:0] h, int seed, int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1;
      in_sop = (i == 0);
      in_data = (i < 8) ? h[63 - 8*i -: 8] : 8'(seed + 3*i);
    end
  endtask

  task automatic idle(int n);
    @(negedge clk);
    in_valid = 0;
    in_sop = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic twrite(int a, bit v, bit clr);
    @(negedge clk);
    tbl_we = 1; tbl_addr = 13'(a); tbl_val = v; tbl_clr = clr;
    @(negedge clk);
    tbl_we = 0; tbl_clr = 0;
  endtask

  task automatic cfg(int off, int wid, bit en);
    @(negedge clk);
    cfg_we = 1; cfg_off_in = 6'(off); cfg_wid_in = 4'(wid); cfg_en_in = en;
    @(negedge clk);
    cfg_we = 0;
  endtask

  function automatic logic [63:0] th(int pid, int tail);
    return {8'h47, 3'b010, 5'(pid >> 8), 8'(pid), 8'h10, 32'(tail)};
  endfunction

  task automatic expect_pkts(int base, int n, string tag, string what);
    idle(400);
    chk(pkt_cnt - base == n, tag, what, pkt_cnt - base, n);
  endtask

  initial begin
    int b;
    repeat (4) @(negedge clk);
    chk(out_valid == 0, "R1", "out_valid in reset", out_valid, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1", "idle after reset", out_valid, 0);

    b = pkt_cnt; send(th(12'h100, 1), 5, PLEN);
    expect_pkts(b, 0, "R1", "empty table drops");

    twrite(12'h100, 1, 0);
    b = pkt_cnt; send(th(12'h100, 2), 9, PLEN);
    expect_pkts(b, 1, "R7", "written bit forwards");

    b = pkt_cnt; send(th(12'h101, 3), 1, PLEN); idle(3); send(th(12'h0ff, 3), 2, PLEN);
    expect_pkts(b, 0, "R4", "unset identifiers dropped");

    twrite(13'h1fff, 1, 0); twrite(0, 1, 0);
    b = pkt_cnt;
    send(th(12'h100, 4), 11, PLEN); send(th(12'h101, 4), 12, PLEN);
    send(th(13'h1fff, 4), 13, PLEN); send(th(0, 4), 14, PLEN);
    send(th(12'h100, 5), 15, PLEN);
    expect_pkts(b, 4, "R10", "back-to-back mix");

    cfg(40, 13, 0);
    b = pkt_cnt; send(th(12'h101, 6), 20, PLEN); send(th(12'h555, 6), 21, PLEN);
    expect_pkts(b, 2, "R5", "bypass forwards all");

    twrite(0, 0, 1);
    cfg(0, 8, 1); twrite(8'h5a, 1, 0);
    b = pkt_cnt;
    send({8'h47, 48'h0, 8'h5a}, 30, PLEN); send({8'h47, 48'h0, 8'h5b}, 31, PLEN);
    expect_pkts(b, 1, "R3", "offset 0 width 8 slice");

    cfg(0, 15, 1); twrite(13'h1234, 1, 0);
    b = pkt_cnt; send({48'h47_0000_0000_00, 8'hf2, 8'h34}, 32, PLEN);
    expect_pkts(b, 1, "R3", "width above 13 truncated");

    cfg(56, 8, 1); twrite(8'h47, 1, 0);
    b = pkt_cnt; send({8'h47, 56'h0}, 33, PLEN);
    expect_pkts(b, 1, "R9", "offset 56 selects byte 0");

    cfg(60, 8, 1);
    b = pkt_cnt; send({8'h47, 56'h0}, 34, PLEN);
    expect_pkts(b, 0, "R3", "slice beyond bit 63 reads 0");

    cfg(40, 13, 1); twrite(12'h100, 1, 0);
    twrite(0, 0, 1);
    b = pkt_cnt; send(th(12'h100, 7), 40, PLEN);
    expect_pkts(b, 0, "R8", "clear drops former pass");

    twrite(12'h100, 1, 1);
    b = pkt_cnt; send(th(12'h100, 8), 41, PLEN);
    expect_pkts(b, 0, "R8", "clear wins over write");

    twrite(12'h100, 1, 0);
    b = pkt_cnt;
    @(negedge clk); in_valid = 1; in_sop = 0; in_data = 8'h47;
    repeat (20) @(negedge clk);
    expect_pkts(b, 0, "R2", "stray bytes ignored");

    b = pkt_cnt;
    send(th(12'h100, 9), 50, 50); send(th(12'h101, 9), 51, PLEN);
    expect_pkts(b, 0, "R2", "restart to dropped packet");

    b = pkt_cnt;
    send(th(12'h101, 10), 52, 60); send(th(12'h100, 10), 53, PLEN);
    expect_pkts(b, 1, "R2", "restart to passed packet");

    twrite(12'h100, 0, 0);
    b = pkt_cnt; send(th(12'h100, 11), 54, PLEN);
    expect_pkts(b, 0, "R7", "write of 0 removes identifier");

    chk(exp_t.size() == 0, "R6", "pending expected bytes", exp_t.size(), 0);
    finish_run();
  end
endmodule